// File: doc/BRIEF.md
# UART Status Flags and Interrupt Requests

This block holds the sticky status flags of a UART and turns them into two level interrupt requests, one for the receive side and one for the transmit side. It performs no serial shifting. The receive and transmit datapaths tell it about events through single-cycle strobes:
- a character has been received;
- a parity error or a framing error occurred;
- the transmit buffer has been moved into the shift register.

It also watches bus reads of the receive data register and bus writes to the transmit data register, the status register and the control register.

Overrun is detected here: a character that completes while the previous one is still unread marks an overrun. Parity, framing and overrun flags, together with the data-ready flag, feed one receive request. These error flags are cleared together by writing 0 to bit 10 of the control register. The transmit request follows the transmit-empty flag. Software reads everything through a 16-bit status word, and the two interrupt enables are the only bits in that word it can write.

Top module: `uart_stat_irq`

## Requirements
- R1: The status word has this layout: bit 15 parity error, bit 14 overrun, bit 13 framing error, bit 12 receive data full, bit 11 transmit data empty, bit 9 receive interrupt enable, bit 8 transmit interrupt enable. Bits 10 and 7..0 always read 0. After reset the word is 16'h0800.
- R2: A receive-complete strobe sets receive data full (bit 12) in the next cycle. This also holds when a receive data read arrives in the same cycle.
- R3: A receive data read without a receive-complete strobe clears bit 12 in the next cycle.
- R4: A receive-complete strobe while bit 12 is 1 and no receive data read is present sets overrun (bit 14). Otherwise overrun is held.
- R5: A parity error strobe sets bit 15 and a framing error strobe sets bit 13. Both flags are sticky.
- R6: A control write with wdata[10]=0 clears bits 15, 14 and 13 together and leaves bit 12 unchanged. A control write with wdata[10]=1 has no effect. A set event in the same cycle wins over the clear.
- R7: Transmit data empty (bit 11) sets on a buffer-to-shift-register move and clears on a transmit data write. If both happen in the same cycle, the write wins and the bit reads 0.
- R8: A status write loads bits 9 and 8 from wdata[9:8]. Writes to bits 15..11 of the status word are ignored.
- R9: rx_irq is high exactly when bit 9 is 1 and at least one of bits 15..12 is 1. It is a level that stays high until that condition goes away.
- R10: tx_irq is high exactly when bit 8 is 1 and bit 11 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | 1 | Receive-complete strobe |
| par_err | input | 1 | Parity error strobe |
| frm_err | input | 1 | Framing error strobe |
| rd_rxdata | input | 1 | Bus read of the receive data register |
| wr_txdata | input | 1 | Bus write of the transmit data register |
| tx_load | input | 1 | Transmit buffer moved into the shift register |
| stat_we | input | 1 | Bus write of the status register |
| ctl_we | input | 1 | Bus write of the control register |
| wdata | input | 16 | Bus write data |
| status | output | 16 | Status word |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The directed sequences each target one case:
- a single receive followed by a read separates the set path of bit 12 from its clear path;
- a second receive before the read separates overrun from a plain re-set;
- a receive and a read in the same cycle shows which one takes priority.

Further sequences test the clear bit. A control write with bit 10 set and with bit 10 clear, with and without a coincident error strobe, distinguishes a working clear from an ignored one and from a lost set. Status writes of all ones and all zeros show whether writes to the flag bits are blocked. A long random mix of strobes and writes, compared every cycle with the behavioural model, covers combinations the directed cases miss.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
  localparam int unsigned STAT_W  = 16;
  localparam int unsigned B_PAR   = 15;
  localparam int unsigned B_OVR   = 14;
  localparam int unsigned B_FRM   = 13;
  localparam int unsigned B_RDF   = 12;
  localparam int unsigned B_TDE   = 11;
  localparam int unsigned B_CLR   = 10;
  localparam int unsigned B_RIE   = 9;
  localparam int unsigned B_TIE   = 8;

  typedef struct packed {
    logic par;
    logic ovr;
    logic frm;
    logic rdf;
  } rx_flags_t;

  typedef struct packed {
    logic rie;
    logic tie;
  } irq_en_t;
endpackage

// File: rtl/uart_rst_sync.sv
module uart_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      rx_done,
  input  logic      par_err,
  input  logic      frm_err,
  input  logic      rd_rxdata,
  input  logic      err_clr,
  output rx_flags_t flags
);
  rx_flags_t flags_q, flags_d;
  logic      ovr_set;
  logic      upd_en;

  always_comb begin
    ovr_set = rx_done && flags_q.rdf && !rd_rxdata;
    upd_en  = rx_done | rd_rxdata | par_err | frm_err | err_clr;
    flags_d = flags_q;
    // data-ready: completion wins over a coincident read
    if (rx_done)        flags_d.rdf = 1'b1;
    else if (rd_rxdata) flags_d.rdf = 1'b0;
    // error flags: new event wins over the group clear
    if (par_err)        flags_d.par = 1'b1;
    else if (err_clr)   flags_d.par = 1'b0;
    if (frm_err)        flags_d.frm = 1'b1;
    else if (err_clr)   flags_d.frm = 1'b0;
    if (ovr_set)        flags_d.ovr = 1'b1;
    else if (err_clr)   flags_d.ovr = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      flags_q <= '0;
    else if (upd_en) flags_q <= flags_d;
  end

  assign flags = flags_q;
endmodule

// File: rtl/uart_tx_flag.sv
module uart_tx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_load,
  input  logic wr_txdata,
  output logic tde
);
  logic tde_q, tde_d, upd_en;

  always_comb begin
    upd_en = tx_load | wr_txdata;
    tde_d  = wr_txdata ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tde_q <= 1'b1;
    else if (upd_en) tde_q <= tde_d;
  end

  assign tde = tde_q;
endmodule

// File: rtl/uart_irq_en.sv
module uart_irq_en
  import uart_stat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  logic    rie_in,
  input  logic    tie_in,
  output irq_en_t en
);
  irq_en_t en_q, en_d;

  always_comb begin
    en_d.rie = rie_in;
    en_d.tie = tie_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= en_d;
  end

  assign en = en_q;
endmodule

// File: rtl/uart_stat_irq.sv
module uart_stat_irq
  import uart_stat_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_done,
  input  logic              par_err,
  input  logic              frm_err,
  input  logic              rd_rxdata,
  input  logic              wr_txdata,
  input  logic              tx_load,
  input  logic              stat_we,
  input  logic              ctl_we,
  input  logic [STAT_W-1:0] wdata,
  output logic [STAT_W-1:0] status,
  output logic              rx_irq,
  output logic              tx_irq
);
  logic      rst_int_n;
  logic      err_clr;
  rx_flags_t rxf;
  irq_en_t   ien;
  logic      tde;
  logic      unused_wdata;

  assign unused_wdata = ^{wdata[STAT_W-1:B_CLR+1], wdata[B_TIE-1:0]};
  assign err_clr      = ctl_we && !wdata[B_CLR];

  uart_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  uart_rx_flags u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_done   (rx_done),
    .par_err   (par_err),
    .frm_err   (frm_err),
    .rd_rxdata (rd_rxdata),
    .err_clr   (err_clr),
    .flags     (rxf)
  );

  uart_tx_flag u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tx_load   (tx_load),
    .wr_txdata (wr_txdata),
    .tde       (tde)
  );

  uart_irq_en u_en (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (stat_we),
    .rie_in (wdata[B_RIE]),
    .tie_in (wdata[B_TIE]),
    .en     (ien)
  );

  always_comb begin
    status        = '0;
    status[B_PAR] = rxf.par;
    status[B_OVR] = rxf.ovr;
    status[B_FRM] = rxf.frm;
    status[B_RDF] = rxf.rdf;
    status[B_TDE] = tde;
    status[B_RIE] = ien.rie;
    status[B_TIE] = ien.tie;
  end

  always_comb begin
    rx_irq = ien.rie & (rxf.par | rxf.ovr | rxf.frm | rxf.rdf);
    tx_irq = ien.tie & tde;
  end
endmodule

// File: rtl/uart_stat_irq_chk.sv
module uart_stat_irq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_done,
  input logic        par_err,
  input logic        frm_err,
  input logic        rd_rxdata,
  input logic        wr_txdata,
  input logic        tx_load,
  input logic        stat_we,
  input logic        ctl_we,
  input logic [15:0] wdata,
  input logic [15:0] status,
  input logic        rx_irq,
  input logic        tx_irq
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status[10] == 1'b0 && status[7:0] == 8'h00);
  // R2
  rdf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> status[12]);
  // R3
  rdf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxdata && !rx_done) |=> !status[12]);
  // R4
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && status[12] && !rd_rxdata) |=> status[14]);
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && !wdata[10] && !rx_done && !par_err && !frm_err) |=> status[15:13] == 3'b000);
  // R6
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ctl_we && !wdata[10])) |=> status[15:13] == ($past(status[15:13]) | status[15:13]));
  // R7
  tde_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txdata |=> !status[11]);
  // R7
  tde_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && !wr_txdata) |=> status[11]);
  // R8
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_we |=> status[9:8] == $past(wdata[9:8]));
  // R9
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq == (status[9] && (status[15:12] != 4'h0)));
  // R10
  tx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq == (status[8] && status[11]));
endmodule

bind uart_stat_irq uart_stat_irq_chk u_chk (.*);

// File: tb/sim_uart_stat_irq.sv
module sim_uart_stat_irq;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_done = 0, par_err = 0, frm_err = 0, rd_rxdata = 0;
  logic        wr_txdata = 0, tx_load = 0, stat_we = 0, ctl_we = 0;
  logic [15:0] wdata = '0;
  logic [15:0] status;
  logic        rx_irq, tx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int m_pe, m_oe, m_fe, m_rdf, m_tde, m_rie, m_tie;

  always #(PERIOD/2) clk = ~clk;

  uart_stat_irq u0 (
    .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .par_err(par_err),
    .frm_err(frm_err), .rd_rxdata(rd_rxdata), .wr_txdata(wr_txdata),
    .tx_load(tx_load), .stat_we(stat_we), .ctl_we(ctl_we), .wdata(wdata),
    .status(status), .rx_irq(rx_irq), .tx_irq(tx_irq)
  );

  function automatic logic [15:0] model_word();
    logic [15:0] w = '0;
    w[15] = m_pe[0]; w[14] = m_oe[0]; w[13] = m_fe[0]; w[12] = m_rdf[0];
    w[11] = m_tde[0]; w[9] = m_rie[0]; w[8] = m_tie[0];
    return w;
  endfunction

  task automatic check(input string tag);
    logic [15:0] ew = model_word();
    logic er = (m_rie != 0) && (m_pe + m_oe + m_fe + m_rdf != 0);
    logic et = (m_tie != 0) && (m_tde != 0);
    checks++;
    if (status !== ew) begin
      errors++;
      $display("FAIL %s status: actual %h expected %h", tag, status, ew);
    end
    checks++;
    if (rx_irq !== er) begin
      errors++;
      $display("FAIL %s rx_irq (R9): actual %b expected %b", tag, rx_irq, er);
    end
    checks++;
    if (tx_irq !== et) begin
      errors++;
      $display("FAIL %s tx_irq (R10): actual %b expected %b", tag, tx_irq, et);
    end
  endtask

  task automatic model_update();
    int clr = (ctl_we && !wdata[10]) ? 1 : 0;
    int ovs = (rx_done && m_rdf != 0 && !rd_rxdata) ? 1 : 0;
    if (rx_done) m_rdf = 1; else if (rd_rxdata) m_rdf = 0;
    if (par_err) m_pe = 1; else if (clr != 0) m_pe = 0;
    if (frm_err) m_fe = 1; else if (clr != 0) m_fe = 0;
    if (ovs != 0) m_oe = 1; else if (clr != 0) m_oe = 0;
    if (wr_txdata) m_tde = 0; else if (tx_load) m_tde = 1;
    if (stat_we) begin m_rie = wdata[9]; m_tie = wdata[8]; end
  endtask

  // one cycle: inputs set at negedge, model follows posedge, compare at next negedge
  task automatic cyc(input logic [8:0] ev, input logic [15:0] wd, input string tag);
    {rx_done, par_err, frm_err, rd_rxdata, wr_txdata, tx_load, stat_we, ctl_we} = ev[7:0];
    wdata = wd;
    @(posedge clk);
    model_update();
    @(negedge clk);
    {rx_done, par_err, frm_err, rd_rxdata, wr_txdata, tx_load, stat_we, ctl_we} = '0;
    check(tag);
  endtask

  // event bit order: rx,par,frm,rd,wtx,load,swe,cwe
  localparam logic [8:0] E_RX = 9'h080, E_PAR = 9'h040, E_FRM = 9'h020, E_RD = 9'h010;
  localparam logic [8:0] E_WTX = 9'h008, E_LD = 9'h004, E_SWE = 9'h002, E_CWE = 9'h001;
  localparam logic [8:0] E_NONE = 9'h000;

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pe = 0; m_oe = 0; m_fe = 0; m_rdf = 0; m_tde = 1; m_rie = 0; m_tie = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset");
    // enables
    cyc(E_SWE, 16'hFFFF, "R8 write all ones, flag bits ignored");
    cyc(E_SWE, 16'h0000, "R8 write zeros");
    cyc(E_SWE, 16'h0300, "R8 enable both");
    // receive path
    cyc(E_RX, 16'h0, "R2 receive sets data full");
    cyc(E_NONE, 16'h0, "R9 level held");
    cyc(E_RD, 16'h0, "R3 read clears data full");
    cyc(E_RX, 16'h0, "R2 receive again");
    cyc(E_RX, 16'h0, "R4 overrun on unread data");
    cyc(E_CWE, 16'h0400, "R6 clear bit written 1 no effect");
    cyc(E_RX | E_RD, 16'h0, "R2 receive wins over read, no overrun");
    cyc(E_CWE, 16'h0000, "R6 clear leaves data full");
    cyc(E_RD, 16'h0, "R3 read clears");
    cyc(E_RX | E_RD, 16'h0, "R4 no overrun when data empty");
    cyc(E_RD, 16'h0, "R3 read clears");
    cyc(E_PAR, 16'h0, "R5 parity sticky");
    cyc(E_FRM, 16'h0, "R5 framing sticky");
    cyc(E_NONE, 16'h0, "R5 hold");
    cyc(E_CWE | E_PAR, 16'h0000, "R6 set wins over clear");
    cyc(E_CWE, 16'h0000, "R6 clear errors");
    cyc(E_SWE, 16'h0100, "R9 rx enable off");
    cyc(E_PAR, 16'h0, "R9 masked by enable");
    cyc(E_SWE, 16'h0200, "R9 rx enable on");
    cyc(E_CWE, 16'h0000, "R9 drops after clear");
    // transmit path
    cyc(E_WTX, 16'h0, "R7 write clears empty");
    cyc(E_LD, 16'h0, "R7 load sets empty");
    cyc(E_WTX | E_LD, 16'h0, "R7 write wins");
    cyc(E_SWE, 16'h0100, "R10 tx enable with buffer full");
    cyc(E_LD, 16'h0, "R10 tx request rises");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [8:0] ev = '0;
      logic [15:0] wd = 16'($urandom);
      if ($urandom_range(0, 3) == 0) ev |= E_RX;
      if ($urandom_range(0, 9) == 0) ev |= E_PAR;
      if ($urandom_range(0, 9) == 0) ev |= E_FRM;
      if ($urandom_range(0, 2) == 0) ev |= E_RD;
      if ($urandom_range(0, 3) == 0) ev |= E_WTX;
      if ($urandom_range(0, 3) == 0) ev |= E_LD;
      if ($urandom_range(0, 7) == 0) ev |= E_SWE;
      if ($urandom_range(0, 5) == 0) ev |= E_CWE;
      cyc(ev, wd, "R4 R6 R7 random mix");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule